// File: doc/BRIEF.md
# Stochastic-Computing Synapse Dot Product

This block forms a weighted sum of a small number of synapse inputs with unipolar stochastic arithmetic. Each signed fixed-point weight (8 integer bits, 8 fraction bits) is turned into a probability by offsetting it to the unsigned range. Each input probability is an unsigned threshold. Every operand has its own linear-feedback shift register, and a comparator against that register turns the operand into a bitstream. Each weight stream is ANDed with its input stream to form a product stream.

The product streams are combined in one of two ways, picked at start. In counting mode every product bit set in a cycle adds to the result. In scaled mode a select stream from a separate shift register picks one product per cycle, which gives the scaled sum divided by the fan-in. A run lasts a power-of-two number of cycles from 32 to 1024, chosen per run by a length select. When the run ends the result count is frozen and a one-cycle done pulse is raised. Dividing the count by the stream length gives the estimate. The expected error shrinks roughly as one half over the square root of the length.

A run always starts from fixed seeds, so each run is fully reproducible. A host picks the stream length per layer to trade latency against accuracy.

Top module: `sc_synapse_dot`

## Requirements
- R1: After reset, count_o is 0 and done_o is 0.
- R2: A weight q (two's complement, DATA_W bits) gives threshold q + 2^(DATA_W-1), which is q with its MSB inverted. An input x is used as an unsigned threshold. Each encoder emits 1 when its register value is strictly below its threshold.
- R3: A product bit is the AND of weight bit i and input bit i. With mode_i = 0 (counting), each cycle adds the number of set product bits to the count.
- R4: With mode_i = 1 (scaled), each cycle adds the product bit whose index equals the low log2(N_IN) bits of the select register. The count therefore never exceeds the run length.
- R5: The run length is 32 << len_sel_i for len_sel_i 0..5, and 1024 for len_sel_i 6 and 7. done_o rises exactly that many clock edges after the edge that accepts start_i.
- R6: done_o is high for exactly one cycle. count_o holds its value after done until the next accepted start.
- R7: start_i, and any change of operands, mode or length while a run is in progress, has no effect on that run's result or timing. Operands are sampled only at the accepted start.
- R8: Each register is a 16-bit Fibonacci LFSR with feedback = XOR of state bits 15, 13, 12 and 10, shifted in at bit 0. It reloads its seed at every accepted start. Register k has seed SEED_BASE + k*SEED_STEP (mod 2^16), with 0 replaced by 1. Weights use k = 0..N_IN-1, inputs use k = N_IN..2*N_IN-1, and the select register uses k = 2*N_IN. A register's state is never zero.
- R9: If every weight is -32768 (threshold 0), the count is 0 in both modes.
- R10: In counting mode with all weights 0 and all inputs 0xFFFF over 1024 cycles, count / (N_IN*1024) lies within 0.125 of 0.5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when no run is active |
| mode_i | input | 1 | 0 = counting sum, 1 = scaled (multiplexed) sum |
| len_sel_i | input | 3 | Stream length select |
| weight_i | input | N_IN*DATA_W | Packed signed weights, weight 0 in the low bits |
| prob_i | input | N_IN*DATA_W | Packed unsigned input probabilities, input 0 in the low bits |
| count_o | output | CNT_W | Ones counted over the run |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The hardest case to reach from the ports is a start request, together with new operands, arriving while a run is in progress. To reach it, the bench raises start_i with different operands midway through a long run. It then checks that the done time and the final count still match the first run. Every count is compared against a bit-level model in the bench that steps the same shift registers from the same seeds. This makes a wrong tap, a wrong seed, a wrong comparison or an off-by-one length show up as a count mismatch. The extremes are checked with directed runs: weights at the negative limit, the shortest length, and out-of-range length codes.

// File: rtl/sc_dot_pkg.sv
package sc_dot_pkg;
  typedef enum logic {
    SUM_COUNT = 1'b0,
    SUM_SCALE = 1'b1
  } sum_mode_e;

  // Seed for register k; all-zero seed would lock the LFSR, so use 1.
  function automatic logic [15:0] seed_of(input logic [15:0] base, input logic [15:0] step,
                                          input int unsigned k);
    logic [15:0] s;
    s = base + 16'(k) * step;
    return (s == 16'd0) ? 16'd1 : s;
  endfunction
endpackage

// File: rtl/sc_lfsr.sv
module sc_lfsr #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'h0001
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= SEED;
    else if (load_i)  state_q <= SEED;
    else if (step_i)  state_q <= {state_q[W-2:0], ^(state_q & TAPS)};
  end

  assign state_o = state_q;

  p_lfsr_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/sc_len_ctrl.sv
module sc_len_ctrl #(
  parameter int unsigned MIN_LOG = 5,
  parameter int unsigned MAX_LOG = 10,
  parameter int unsigned SEL_W   = 3,
  localparam int unsigned LEN_W  = MAX_LOG + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] len_sel_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned MAX_SEL = MAX_LOG - MIN_LOG;

  logic [LEN_W-1:0] len_d, len_q, cyc_q;
  logic             busy_q, done_q;

  always_comb begin
    if (32'(len_sel_i) > MAX_SEL) len_d = LEN_W'(1) << MAX_LOG;
    else                          len_d = LEN_W'(1) << (MIN_LOG + 32'(len_sel_i));
  end

  assign accept_o = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cyc_q  <= '0;
      len_q  <= LEN_W'(1) << MIN_LOG;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        busy_q <= 1'b1;
        cyc_q  <= '0;
        len_q  <= len_d;
      end else if (busy_q) begin
        cyc_q <= cyc_q + 1'b1;
        if (cyc_q == len_q - 1'b1) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  p_cycle_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cyc_q < len_q));
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_after_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(busy_q));
endmodule

// File: rtl/sc_combine.sv
module sc_combine #(
  parameter int unsigned N_IN  = 4,
  localparam int unsigned SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int unsigned INC_W = $clog2(N_IN + 1)
) (
  input  logic [N_IN-1:0]  prod_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             scale_i,
  output logic [INC_W-1:0] inc_o
);
  logic [INC_W-1:0] pop;

  always_comb begin
    pop = '0;
    for (int i = 0; i < N_IN; i++) pop = pop + INC_W'(prod_i[i]);
  end

  // Index select is the 2:1 mux tree driven by the select stream bits.
  assign inc_o = scale_i ? INC_W'(prod_i[sel_i]) : pop;

  always_comb begin
    a_scale_single_r4: assert (!scale_i || inc_o <= INC_W'(1));
  end
endmodule

// File: rtl/sc_synapse_dot.sv
module sc_synapse_dot
  import sc_dot_pkg::*;
#(
  parameter int unsigned N_IN      = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MIN_LOG   = 5,
  parameter int unsigned MAX_LOG   = 10,
  parameter logic [15:0] SEED_BASE = 16'hACE1,
  parameter logic [15:0] SEED_STEP = 16'h1F35,
  parameter logic [15:0] TAPS      = 16'hB400,
  localparam int unsigned CNT_W    = $clog2(N_IN * (1 << MAX_LOG) + 1),
  localparam int unsigned INC_W    = $clog2(N_IN + 1),
  localparam int unsigned SEL_W    = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     mode_i,
  input  logic [2:0]               len_sel_i,
  input  logic [N_IN*DATA_W-1:0]   weight_i,
  input  logic [N_IN*DATA_W-1:0]   prob_i,
  output logic [CNT_W-1:0]         count_o,
  output logic                     done_o
);
  localparam int unsigned N_REG = 2 * N_IN + 1;

  logic                   accept, busy;
  logic [N_IN*DATA_W-1:0] w_thr_q, x_thr_q;
  sum_mode_e              mode_q;
  logic [DATA_W-1:0]      lfsr_st [N_REG];
  logic [N_IN-1:0]        prod;
  logic [INC_W-1:0]       inc;
  logic [CNT_W-1:0]       count_q;

  sc_len_ctrl #(
    .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .SEL_W(3)
  ) i_ctrl (
    .clk_i, .rst_ni, .start_i, .len_sel_i,
    .accept_o(accept), .busy_o(busy), .done_o
  );

  for (genvar k = 0; k < N_REG; k++) begin : g_lfsr
    sc_lfsr #(
      .W(DATA_W), .TAPS(DATA_W'(TAPS)),
      .SEED(DATA_W'(seed_of(SEED_BASE, SEED_STEP, k)))
    ) i_lfsr (
      .clk_i, .rst_ni, .load_i(accept), .step_i(busy), .state_o(lfsr_st[k])
    );
  end

  // Operand capture; weight offset to unipolar by inverting its sign bit.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_thr_q <= '0;
      x_thr_q <= '0;
      mode_q  <= SUM_COUNT;
    end else if (accept) begin
      for (int i = 0; i < N_IN; i++) begin
        w_thr_q[i*DATA_W +: DATA_W] <= weight_i[i*DATA_W +: DATA_W] ^ {1'b1, {(DATA_W-1){1'b0}}};
      end
      x_thr_q <= prob_i;
      mode_q  <= sum_mode_e'(mode_i);
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_enc
    logic w_bit, x_bit;
    assign w_bit   = lfsr_st[i] < w_thr_q[i*DATA_W +: DATA_W];
    assign x_bit   = lfsr_st[N_IN+i] < x_thr_q[i*DATA_W +: DATA_W];
    assign prod[i] = w_bit & x_bit;
  end

  sc_combine #(.N_IN(N_IN)) i_combine (
    .prod_i(prod),
    .sel_i(lfsr_st[2*N_IN][SEL_W-1:0]),
    .scale_i(mode_q == SUM_SCALE),
    .inc_o(inc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (accept) count_q <= '0;
    else if (busy)   count_q <= count_q + CNT_W'(inc);
  end

  assign count_o = count_q;

  p_hold_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> $stable(count_q));
  p_scale_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && mode_q == SUM_SCALE && !accept) |=>
      ({1'b0, count_q} <= {1'b0, $past(count_q)} + 1'b1));
  p_clear_on_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (count_q == '0));
endmodule

// File: tb/test_sc_synapse_dot.sv
`timescale 1ns/1ps
module test_sc_synapse_dot;
  localparam int N = 4;
  localparam logic [15:0] BASE = 16'hACE1;
  localparam logic [15:0] STEP = 16'h1F35;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, mode_i = 1'b0;
  logic [2:0] len_sel_i = '0;
  logic [63:0] weight_i = '0, prob_i = '0;
  logic [12:0] count_o;
  logic done_o;

  int n_tests = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  sc_synapse_dot #(.N_IN(N), .SEED_BASE(BASE), .SEED_STEP(STEP)) i_sc_synapse_dot (
    .clk_i, .rst_ni, .start_i, .mode_i, .len_sel_i,
    .weight_i, .prob_i, .count_o, .done_o
  );

  typedef struct packed {
    logic [63:0] w;
    logic [63:0] x;
    logic        mode;
    logic [2:0]  lsel;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 3'd0},
    '{64'h7FFF_4000_C000_0100, 64'h8000_2000_F000_1234, 1'b0, 3'd1},
    '{64'h1234_8001_7F00_E000, 64'hFFFF_0001_8000_AAAA, 1'b1, 3'd2},
    '{64'h3000_3000_3000_3000, 64'hC000_C000_C000_C000, 1'b1, 3'd3},
    '{64'hF800_0800_0000_7FFF, 64'h5555_AAAA_FFFF_0000, 1'b0, 3'd4},
    '{64'h2222_DDDD_4444_BBBB, 64'h9999_6666_3333_CCCC, 1'b1, 3'd5},
    '{64'h0100_0200_0300_0400, 64'hE000_D000_C000_B000, 1'b0, 3'd6},
    '{64'h7FFF_7FFF_7FFF_7FFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 3'd7}
  };

  function automatic logic [15:0] seed(int k);
    logic [15:0] s;
    s = BASE + 16'(k) * STEP;
    return (s == 0) ? 16'd1 : s;
  endfunction

  function automatic int len_of(logic [2:0] lsel);
    return (lsel > 3'd5) ? 1024 : (32 << lsel);
  endfunction

  function automatic int model(logic [63:0] w, logic [63:0] x, logic mode, logic [2:0] lsel);
    logic [15:0] st [9];
    logic [3:0] p;
    int acc = 0;
    for (int k = 0; k < 9; k++) st[k] = seed(k);
    for (int c = 0; c < len_of(lsel); c++) begin
      for (int i = 0; i < N; i++) begin
        p[i] = (st[i] < {~w[i*16+15], w[i*16 +: 15]}) && (st[N+i] < x[i*16 +: 16]);
      end
      if (mode) acc += int'(p[st[8][1:0]]);
      else      acc += int'(p[0]) + int'(p[1]) + int'(p[2]) + int'(p[3]);
      for (int k = 0; k < 9; k++) st[k] = {st[k][14:0], ^(st[k] & 16'hB400)};
    end
    return acc;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Start a run and count edges until done; optional mid-run disturbance.
  task automatic run(logic [63:0] w, logic [63:0] x, logic mode, logic [2:0] lsel,
                     bit disturb, output int cnt, output int edges);
    @(negedge clk_i);
    weight_i = w; prob_i = x; mode_i = mode; len_sel_i = lsel; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    edges = 1;
    while (!done_o && edges < 2000) begin
      if (disturb && edges == 10) begin
        start_i = 1'b1; weight_i = ~w; prob_i = ~x; mode_i = ~mode; len_sel_i = 3'd0;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
      edges++;
    end
    edges--;
    start_i = 1'b0;
    cnt = int'(count_o);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c, e, c2;
    // R1 reset state
    #12 check("R1 count", int'(count_o), 0);
    check("R1 done", int'(done_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // Table: R2 R3 R4 R5 R8 against bit-level model
    foreach (VECS[v]) begin
      run(VECS[v].w, VECS[v].x, VECS[v].mode, VECS[v].lsel, 1'b0, c, e);
      check(VECS[v].mode ? "R4 scaled count" : "R3 counting count", c,
            model(VECS[v].w, VECS[v].x, VECS[v].mode, VECS[v].lsel));
      check("R5 run length", e, len_of(VECS[v].lsel));
      if (VECS[v].mode) check("R4 count within length", int'(c <= len_of(VECS[v].lsel)), 1);
    end

    // R6 done is one cycle, count held afterwards
    run(VECS[1].w, VECS[1].x, 1'b0, 3'd0, 1'b0, c, e);
    @(negedge clk_i);
    check("R6 done pulse width", int'(done_o), 0);
    repeat (5) @(negedge clk_i);
    weight_i = '0; prob_i = '0;
    @(negedge clk_i);
    check("R6 count held", int'(count_o), c);

    // R7 start and operand changes during run ignored
    run(VECS[4].w, VECS[4].x, 1'b0, 3'd3, 1'b1, c, e);
    check("R7 count unaffected", c, model(VECS[4].w, VECS[4].x, 1'b0, 3'd3));
    check("R7 timing unaffected", e, 256);

    // R8 reseeding: repeat identical run gives identical count
    run(VECS[2].w, VECS[2].x, 1'b1, 3'd2, 1'b0, c, e);
    run(VECS[2].w, VECS[2].x, 1'b1, 3'd2, 1'b0, c2, e);
    check("R8 reseed repeatable", c2, c);

    // R9 weights at negative limit give zero
    run({4{16'h8000}}, {4{16'hFFFF}}, 1'b0, 3'd2, 1'b0, c, e);
    check("R9 counting zero", c, 0);
    run({4{16'h8000}}, {4{16'hFFFF}}, 1'b1, 3'd2, 1'b0, c, e);
    check("R9 scaled zero", c, 0);

    // R10 estimate near 0.5 within bound
    run(64'h0, {4{16'hFFFF}}, 1'b0, 3'd5, 1'b0, c, e);
    check("R10 estimate in band", int'(c >= 1536 && c <= 2560), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule